// File: doc/BRIEF.md
# USB Bus Event Detector

This block watches the decoded line state of an upstream USB port and turns bus conditions into sticky event flags. It recognises a bus reset (SE0 held long enough), two idle durations that lead to suspend (a shorter one that tells firmware to suspend and a longer one that allows remote wake-up), resume signalling while the node is suspended, and a valid end-of-packet. Firmware uses the end-of-packet flag to confirm that its own remote wake-up has finished.

Idle time is measured in units of a 1 µs tick input. SE0 length is measured in system clock cycles. The flags form one event register, and a read strobe clears the whole register. If an event arrives in the same cycle as the read, that flag stays set, so no event is lost. A mask input selects which flags drive a single summary output, which feeds the ALT bit of the main event register.

Top module: `usb_bus_evt`

## Requirements
- R1: After reset, `evt_o` is 0 and `alt_o` is 0.
- R2: The idle-short flag (`evt_o[1]`) sets after the line has been J (`line_i`=2'b01) without a break for IDLE3_TICKS ticks. It does not set after one tick less.
- R3: The idle-long flag (`evt_o[2]`) sets after the line has been J without a break for IDLE5_TICKS ticks.
- R4: Each idle flag sets at most once per idle period. Any non-J line state restarts the idle count from zero.
- R5: The bus-reset flag (`evt_o[0]`) sets once SE0 (`line_i`=2'b00) has lasted RESET_CYC consecutive clock cycles. A shorter SE0 run does not set it.
- R6: The resume flag (`evt_o[3]`) sets only while `node_state_i` is 2'b11 (suspend) and the line is not J (for example K, 2'b10). In any other node state, a non-J line has no effect.
- R7: The end-of-packet flag (`evt_o[4]`) sets when the line goes straight to J after an SE0 run of at least EOP_CYC cycles. It does not set after a shorter SE0 run, or when SE0 is followed by K.
- R8: A cycle with `rd_i` high clears every flag in `evt_o` at the next clock edge.
- R9: A flag whose event occurs in the same cycle as `rd_i` is set after that edge.
- R10: `alt_o` is high exactly when some flag is set and its bit in `mask_i` (same bit positions as `evt_o`) is 1. A masked flag has no effect on `alt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Decoded line state: 00 SE0, 01 J/idle, 10 K, 11 SE1 |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| node_state_i | input | 2 | Node functional state; 11 means suspend |
| rd_i | input | 1 | Event register read strobe |
| mask_i | input | 5 | Enables for the summary output, one bit per event |
| evt_o | output | 5 | Event flags: 0 reset, 1 idle-short, 2 idle-long, 3 resume, 4 end-of-packet |
| alt_o | output | 1 | Masked summary of the event flags |

## Verification
The bench counts ticks up to exactly one short of each idle threshold and then to the threshold itself. A counter that is off by one therefore shows up as an early or late flag. It breaks an idle period with a single K cycle to catch a count that is never restarted, and it stays idle well past the long threshold to catch flags that set again. SE0 runs one cycle below and exactly at the reset length, and SE0 runs below the end-of-packet minimum or followed by K, catch thresholds placed wrongly and end-of-packet detection that ignores what follows the SE0. A read strobe placed in the cycle of the reset event catches a clear that takes priority over the set. Resume is tried outside suspend, and the summary is checked under masks that cover and exclude the pending flag, to catch a missing state gate or a missing mask.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  localparam logic [1:0] NODE_SUSPEND = 2'b11;

  localparam int NUM_EVT  = 5;
  localparam int EV_RESET = 0;
  localparam int EV_IDLE3 = 1;
  localparam int EV_IDLE5 = 2;
  localparam int EV_RESUM = 3;
  localparam int EV_EOP   = 4;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int IDLE3_TICKS = 3000,
  parameter int IDLE5_TICKS = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic tick_i,
  output logic s3_hit_o,
  output logic s5_hit_o
);
  localparam int W = $clog2(IDLE5_TICKS + 1);
  localparam logic [W-1:0] LIM3 = W'(IDLE3_TICKS - 1);
  localparam logic [W-1:0] LIM5 = W'(IDLE5_TICKS - 1);
  localparam logic [W-1:0] SAT  = W'(IDLE5_TICKS);

  logic [W-1:0] cnt_q;
  logic         step;

  assign step     = idle_i && tick_i && (cnt_q != SAT);
  assign s3_hit_o = step && (cnt_q == LIM3);
  assign s5_hit_o = step && (cnt_q == LIM5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!idle_i) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  p_idle_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT);
  p_idle_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_hit_o |=> !s3_hit_o);
  p_idle_break_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> cnt_q == '0);
endmodule

// File: rtl/usb_se0_timer.sv
module usb_se0_timer #(
  parameter int RESET_CYC = 125,
  parameter int EOP_CYC   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  output logic       rst_hit_o,
  output logic       eop_hit_o
);
  import usb_evt_pkg::*;

  localparam int W = $clog2(RESET_CYC + 1);
  localparam logic [W-1:0] LIMR = W'(RESET_CYC - 1);
  localparam logic [W-1:0] SAT  = W'(RESET_CYC);
  localparam logic [W-1:0] EMIN = W'(EOP_CYC);

  logic [W-1:0] run_q;
  logic         is_se0;

  assign is_se0    = (line_i == LS_SE0);
  assign rst_hit_o = is_se0 && (run_q == LIMR);
  // run_q still holds the length of the SE0 run that just ended
  assign eop_hit_o = (line_i == LS_J) && (run_q >= EMIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!is_se0)     run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  p_rst_on_se0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_hit_o |-> $past(line_i) == LS_SE0 || run_q == '0);
  p_eop_after_se0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_hit_o |-> $past(line_i) == LS_SE0);
  p_run_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= SAT);
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic         rd_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         alt_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (hit_i[i]) flag_q[i] <= 1'b1;  // set wins over clear-on-read
      else if (rd_i)     flag_q[i] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign alt_o   = |(flag_q & mask_i);

  p_rd_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && hit_i == '0 |=> flag_q == '0);
  p_set_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i != '0 |=> (flag_q & $past(hit_i)) == $past(hit_i));
  p_alt_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q == '0 |-> !alt_o);
endmodule

// File: rtl/usb_bus_evt.sv
module usb_bus_evt #(
  parameter int IDLE3_TICKS = 3000,
  parameter int IDLE5_TICKS = 5000,
  parameter int RESET_CYC   = 125,
  parameter int EOP_CYC     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  input  logic       tick_i,
  input  logic [1:0] node_state_i,
  input  logic       rd_i,
  input  logic [4:0] mask_i,
  output logic [4:0] evt_o,
  output logic       alt_o
);
  import usb_evt_pkg::*;

  logic [NUM_EVT-1:0] hit;
  logic s3_hit, s5_hit, rst_hit, eop_hit, res_hit;

  usb_idle_timer #(.IDLE3_TICKS(IDLE3_TICKS), .IDLE5_TICKS(IDLE5_TICKS)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idle_i   (line_i == LS_J),
    .tick_i   (tick_i),
    .s3_hit_o (s3_hit),
    .s5_hit_o (s5_hit)
  );

  usb_se0_timer #(.RESET_CYC(RESET_CYC), .EOP_CYC(EOP_CYC)) u_se0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_i),
    .rst_hit_o (rst_hit),
    .eop_hit_o (eop_hit)
  );

  assign res_hit = (node_state_i == NODE_SUSPEND) && (line_i != LS_J);

  always_comb begin
    hit           = '0;
    hit[EV_RESET] = rst_hit;
    hit[EV_IDLE3] = s3_hit;
    hit[EV_IDLE5] = s5_hit;
    hit[EV_RESUM] = res_hit;
    hit[EV_EOP]   = eop_hit;
  end

  usb_evt_flags #(.N(NUM_EVT)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .rd_i    (rd_i),
    .mask_i  (mask_i),
    .flags_o (evt_o),
    .alt_o   (alt_o)
  );

  p_resume_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[EV_RESUM]) |-> $past(node_state_i) == NODE_SUSPEND);
  p_idle_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[EV_IDLE5]) |-> $past(line_i) == LS_J);
endmodule

// File: tb/usb_bus_evt_test.sv
module usb_bus_evt_test;
  localparam int I3 = 12, I5 = 20, RC = 10, EC = 3;

  logic       clk = 0, rst_ni = 0, tick = 0, rd = 0;
  logic [1:0] line = 2'b01, node = 2'b10;
  logic [4:0] mask = '0;
  logic [4:0] evt;
  logic       alt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  usb_bus_evt #(.IDLE3_TICKS(I3), .IDLE5_TICKS(I5), .RESET_CYC(RC), .EOP_CYC(EC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .tick_i(tick),
    .node_state_i(node), .rd_i(rd), .mask_i(mask), .evt_o(evt), .alt_o(alt)
  );

  // monitor: compare read data against scoreboard
  always @(negedge clk) begin
    if (rd && exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (evt !== e) begin
        n_bad++;
        $display("FAIL %s: evt got %b expected %b", t, evt, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic read_expect(input logic [4:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd = 1;
    cyc(1);
    rd = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin tick = 1; cyc(1); tick = 0; cyc(1); end
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(1);
    chk(evt == 5'b0, 1'b1, "R1 evt");
    chk(alt, 1'b0, "R1 alt");

    // idle thresholds
    line = 2'b10; cyc(2); line = 2'b01;
    ticks(I3 - 1);
    read_expect(5'b00000, "R2 one tick short");
    ticks(1);
    read_expect(5'b00010, "R2 idle-short");
    ticks(I5 - I3);
    read_expect(5'b00100, "R3 idle-long");
    read_expect(5'b00000, "R8 cleared");
    ticks(30);
    read_expect(5'b00000, "R4 no repeat");

    // break restarts count
    line = 2'b10; cyc(1); line = 2'b01;
    ticks(I3 - 1);
    line = 2'b10; cyc(1); line = 2'b01;
    ticks(I3 - 1);
    read_expect(5'b00000, "R4 restart");
    ticks(1);
    read_expect(5'b00010, "R4 after restart");

    // SE0 runs
    line = 2'b00; cyc(RC - 1); line = 2'b01; cyc(1);
    read_expect(5'b10000, "R5 short SE0 / R7 eop");
    line = 2'b00; cyc(RC); line = 2'b01; cyc(1);
    read_expect(5'b10001, "R5 reset");
    line = 2'b00; cyc(EC - 1); line = 2'b01; cyc(1);
    read_expect(5'b00000, "R7 short SE0");
    line = 2'b00; cyc(EC + 2); line = 2'b10; cyc(1); line = 2'b01; cyc(1);
    read_expect(5'b00000, "R7 SE0 then K");

    // resume gating
    line = 2'b10; cyc(3); line = 2'b01; cyc(1);
    read_expect(5'b00000, "R6 not suspended");
    node = 2'b11; cyc(1);
    line = 2'b10; cyc(1); line = 2'b01; cyc(1);
    read_expect(5'b01000, "R6 resume");
    cyc(2);
    read_expect(5'b00000, "R6 idle in suspend");

    // read in the event cycle
    node = 2'b10;
    line = 2'b00; cyc(RC - 1);
    read_expect(5'b00000, "R9 read at event");
    line = 2'b10; cyc(1);
    read_expect(5'b00001, "R9 flag kept");

    // mask / summary
    line = 2'b01; node = 2'b11; cyc(1);
    line = 2'b10; cyc(1); line = 2'b01; node = 2'b10; cyc(1);
    chk(alt, 1'b0, "R10 masked");
    mask = 5'b01000; cyc(1);
    chk(alt, 1'b1, "R10 enabled");
    mask = 5'b10111; cyc(1);
    chk(alt, 1'b0, "R10 other bits");
    mask = 5'b01000;
    read_expect(5'b01000, "R10 pending flag");
    chk(alt, 1'b0, "R10 after read");

    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule